// File: doc/BRIEF.md
# Dual-Mode Oversampling Baud Tick Generator

This block turns a fast peripheral clock into the one-cycle oversample tick (sixteen per bit) that paces an asynchronous serial transmitter and receiver. It offers two ways of making that tick, and a mode input picks one of them.

In integer mode, a 16-bit reload value sets a down-counter. The counter emits a tick each time it wraps, so the tick period is exactly the reload value in clocks. The reload for a target rate is the clock divided by sixteen times the bit rate. This mode suits the slower rates, below 19200 bit/s.

In phase mode, the reload value is added every clock to a 16-bit phase register, and each carry out of that register emits a tick. The reload is then the bit rate times sixteen times 65536, divided by the clock. Because this mode gives fractional resolution, it reaches 19200 bit/s and above with small error.

Software drops the run input, writes a reload value over a one-cycle write strobe, and then raises run together with the chosen mode. A reload written while the generator is running is held back until the next wrap, so no tick period is ever cut short.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `os_tick` is low and the stored reload value is 0. Running in integer mode straight after reset therefore ticks on every clock.
- R2: In integer mode (`acc_mode`=0) with reload R >= 2, ticks appear on running clock edges 1, R+1, 2R+1 and so on, counted from the first clock edge with `run_en` high. Each tick is visible in the cycle after its edge and is one cycle wide.
- R3: In phase mode (`acc_mode`=1), after k running clock edges the number of ticks is exactly floor(k*R/65536), because the phase starts from 0 and a tick marks each carry out of bit 15.
- R4: While `run_en` is low, no tick is produced and the counter and phase are cleared. Each new run starts from the state that R2 and R3 describe.
- R5: In integer mode, a reload of 0 or 1 makes a tick on every clock.
- R6: A write (`reload_wr` high for one clock) while `run_en` is low takes effect from the next run. A write while running takes effect only at the next wrap of the active engine, and the period in progress completes at the old value.
- R7: `acc_mode`=1 selects the phase mode and `acc_mode`=0 selects the integer mode. The same reload value gives the tick counts of the selected mode only.
- R8: With a 200 MHz clock assumed, reloads from the two formulas give a tick period within 1% of clock/(16*rate) for 9600 bit/s in integer mode and for 19200, 38400, 57600 and 115200 bit/s in phase mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Generator runs while high |
| acc_mode | input | 1 | 1 = phase (carry) mode, 0 = integer divider mode |
| reload_wr | input | 1 | One-cycle write strobe for the reload value |
| reload_data | input | RELOAD_W (16) | Reload value written on `reload_wr` |
| os_tick | output | 1 | One-cycle oversample tick |

## Verification
The integer divider is driven with reloads 0, 1, 2 and 7 and with random reloads up to 300. The tick counts show the first-edge tick and the wrap period, and they separate the every-clock case from an off-by-one period. The phase mode is driven with reloads 0, 32768 and 65535 and with random values, and the exact floor-of-product count exposes a carry that is dropped or doubled. Timed traces with a mid-run write show that the new value waits for the wrap in each mode. The same reload applied in both modes shows which engine the mode input selects. At the five standard rates the measured periods are compared against the 1% error bound.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

    localparam int unsigned RELOAD_W_DEF = 16;

    typedef enum logic {
        GEN_DIV = 1'b0,
        GEN_ACC = 1'b1
    } gen_mode_e;

    typedef struct packed {
        logic wrap;
        logic tick;
    } eng_out_t;

endpackage

// File: rtl/bgen_reload_ctl.sv
module bgen_reload_ctl #(
    parameter int unsigned W = bgen_pkg::RELOAD_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    input  logic         wrap_i,
    output logic [W-1:0] act_o,
    output logic [W-1:0] next_o
);
    logic [W-1:0] act_q;
    logic [W-1:0] pend_q;
    logic         pend_v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (!run_en) begin
            if (pend_v_q) act_q <= pend_q;
            pend_v_q <= 1'b0;
            if (wr_i) act_q <= data_i;
        end else begin
            if (wrap_i && pend_v_q) begin
                act_q    <= pend_q;
                pend_v_q <= 1'b0;
            end
            if (wr_i) begin
                pend_q   <= data_i;
                pend_v_q <= 1'b1;
            end
        end
    end

    assign act_o  = act_q;
    assign next_o = pend_v_q ? pend_q : act_q;
endmodule

// File: rtl/bgen_div_engine.sv
module bgen_div_engine #(
    parameter int unsigned W = bgen_pkg::RELOAD_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [W-1:0]       next_reload,
    output bgen_pkg::eng_out_t out_o
);
    logic [W-1:0] cnt_q;
    logic         tick_q;
    logic         wrap_now;

    assign wrap_now = en && (cnt_q <= W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (wrap_now) begin
            cnt_q  <= next_reload;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q - W'(1);
            tick_q <= 1'b0;
        end
    end

    assign out_o.wrap = wrap_now;
    assign out_o.tick = tick_q;
endmodule

// File: rtl/bgen_acc_engine.sv
module bgen_acc_engine #(
    parameter int unsigned W = bgen_pkg::RELOAD_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [W-1:0]       step,
    output bgen_pkg::eng_out_t out_o
);
    logic [W-1:0] phase_q;
    logic         tick_q;
    logic [W:0]   sum;

    assign sum = {1'b0, phase_q} + {1'b0, step};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase_q <= '0;
            tick_q  <= 1'b0;
        end else begin
            phase_q <= sum[W-1:0];
            tick_q  <= sum[W];
        end
    end

    assign out_o.wrap = en && sum[W];
    assign out_o.tick = tick_q;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int unsigned RELOAD_W = bgen_pkg::RELOAD_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_en,
    input  logic                acc_mode,
    input  logic                reload_wr,
    input  logic [RELOAD_W-1:0] reload_data,
    output logic                os_tick
);
    import bgen_pkg::*;

    gen_mode_e          mode_sel;
    logic               div_en;
    logic               acc_en;
    logic [RELOAD_W-1:0] act_reload;
    logic [RELOAD_W-1:0] next_reload;
    eng_out_t           div_out;
    eng_out_t           acc_out;
    logic               any_wrap;

    assign mode_sel = gen_mode_e'(acc_mode);
    assign div_en   = run_en && (mode_sel == GEN_DIV);
    assign acc_en   = run_en && (mode_sel == GEN_ACC);
    assign any_wrap = div_out.wrap | acc_out.wrap;

    bgen_reload_ctl #(.W(RELOAD_W)) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .wr_i   (reload_wr),
        .data_i (reload_data),
        .wrap_i (any_wrap),
        .act_o  (act_reload),
        .next_o (next_reload)
    );

    bgen_div_engine #(.W(RELOAD_W)) u_div (
        .clk         (clk),
        .rst         (rst),
        .en          (div_en),
        .next_reload (next_reload),
        .out_o       (div_out)
    );

    bgen_acc_engine #(.W(RELOAD_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .en    (acc_en),
        .step  (act_reload),
        .out_o (acc_out)
    );

    assign os_tick = div_out.tick | acc_out.tick;
endmodule

// File: rtl/bgen_checker.sv
module bgen_checker #(
    parameter int unsigned W = bgen_pkg::RELOAD_W_DEF
) (
    input logic         clk,
    input logic         rst,
    input logic         run_en,
    input logic         acc_mode,
    input logic         tick,
    input logic [W-1:0] act_reload
);
    localparam logic [W:0] GAP_MAX = {1'b1, {W{1'b0}}};

    logic [W:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst || !run_en || acc_mode || tick) gap_q <= '0;
        else if (gap_q != {(W+1){1'b1}}) gap_q <= gap_q + 1'b1;
    end

    // R1: reset keeps the tick low
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !tick);

    // R4: no tick follows a stopped cycle
    a_r4_idle_no_tick: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> !tick);

    // R5: integer mode with reload 0 or 1 ticks every clock
    a_r5_fast_div: assert property (@(posedge clk) disable iff (rst)
        (run_en && !acc_mode && act_reload <= W'(1)) |=> tick);

    // R3: a zero step in phase mode never carries
    a_r3_acc_zero_step: assert property (@(posedge clk) disable iff (rst)
        (run_en && acc_mode && act_reload == '0) |=> !tick);

    // R2: integer period never exceeds the reload range
    a_r2_div_gap: assert property (@(posedge clk) disable iff (rst)
        gap_q < GAP_MAX);
endmodule

bind baud_tick_gen bgen_checker #(.W(RELOAD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .acc_mode   (acc_mode),
    .tick       (os_tick),
    .act_reload (act_reload)
);

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        acc_mode = 1'b0;
    logic        reload_wr = 1'b0;
    logic [15:0] reload_data = '0;
    logic        os_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    baud_tick_gen dut (
        .clk(clk), .rst(rst), .run_en(run_en), .acc_mode(acc_mode),
        .reload_wr(reload_wr), .reload_data(reload_data), .os_tick(os_tick)
    );

    function automatic longint exp_div(longint c, longint r);
        if (r <= 1) return c;
        return (c - 1) / r + 1;
    endfunction

    function automatic longint exp_acc(longint c, longint r);
        return (c * r) / 65536;
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_le(string req, longint act, longint lim);
        n_checks++;
        if (act > lim) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected<=%0d", req, act, lim);
        end
    endtask

    task automatic stop_gen();
        run_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_stopped(bit mode, logic [15:0] r);
        run_en      = 1'b0;
        acc_mode    = mode;
        reload_wr   = 1'b1;
        reload_data = r;
        @(negedge clk);
        reload_wr   = 1'b0;
    endtask

    task automatic run_count(int c, output longint n);
        n = 0;
        run_en = 1'b1;
        for (int k = 0; k < c; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (os_tick) n++;
        end
        stop_gen();
    endtask

    task automatic run_trace(int c, int wr_edge, logic [15:0] wv,
                             output logic [63:0] mask);
        mask = '0;
        run_en = 1'b1;
        for (int k = 1; k <= c; k++) begin
            @(posedge clk);
            @(negedge clk);
            mask[k] = os_tick;
            if (k == wr_edge - 1) begin
                reload_wr = 1'b1;
                reload_data = wv;
            end
            if (k == wr_edge) reload_wr = 1'b0;
        end
        stop_gen();
    endtask

    task automatic measure(bit mode, logic [15:0] r, int nt, output real period);
        int cyc = 0, seen = 0, first = 0, last = 0;
        write_stopped(mode, r);
        run_en = 1'b1;
        while (seen < nt && cyc < 40000) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (os_tick) begin
                if (seen == 0) first = cyc;
                last = cyc;
                seen++;
            end
        end
        stop_gen();
        period = (seen > 1) ? real'(last - first) / real'(seen - 1) : 0.0;
    endtask

    task automatic rate_check(string req, bit mode, longint bps, int nt);
        real clk_hz = 200.0e6;
        real ideal, meas;
        longint r;
        ideal = clk_hz / (16.0 * real'(bps));
        if (mode) r = longint'((real'(bps) * 16.0 * 65536.0) / clk_hz + 0.5);
        else      r = longint'(clk_hz) / (16 * bps);
        measure(mode, r[15:0], nt, meas);
        check_le(req, longint'(((meas > ideal) ? meas - ideal : ideal - meas)
                 / ideal * 1.0e6), 10000);
    endtask

    initial begin
        #(190000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        longint n;
        logic [63:0] m;
        logic [63:0] m_exp;
        process::self().srandom(32'd12345);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: quiet after reset, stored reload 0 -> every clock in integer mode
        check("R1 tick low after reset", os_tick, 0);
        run_count(12, n);
        check("R1 reset reload is zero", n, 12);

        // R5: reload 0 and 1
        write_stopped(0, 16'd1);
        run_count(20, n);
        check("R5 reload 1", n, 20);
        write_stopped(0, 16'd0);
        run_count(15, n);
        check("R5 reload 0", n, 15);

        // R2: directed integer periods
        write_stopped(0, 16'd2);
        run_count(21, n);
        check("R2 reload 2", n, exp_div(21, 2));
        write_stopped(0, 16'd7);
        run_count(50, n);
        check("R2 reload 7", n, exp_div(50, 7));

        // R2: random integer reloads
        for (int i = 0; i < 8; i++) begin
            int r = $urandom_range(299, 0);
            int c = $urandom_range(800, 500);
            write_stopped(0, r[15:0]);
            run_count(c, n);
            check("R2 random reload", n, exp_div(c, r));
        end

        // R3: directed phase steps
        write_stopped(1, 16'd0);
        run_count(100, n);
        check("R3 step 0", n, 0);
        write_stopped(1, 16'hFFFF);
        run_count(1000, n);
        check("R3 step 65535", n, exp_acc(1000, 65535));
        write_stopped(1, 16'h8000);
        run_count(101, n);
        check("R3 step 32768", n, exp_acc(101, 32768));

        // R3: random phase steps
        for (int i = 0; i < 10; i++) begin
            int r = $urandom_range(65535, 0);
            int c = $urandom_range(1500, 600);
            write_stopped(1, r[15:0]);
            run_count(c, n);
            check("R3 random step", n, exp_acc(c, r));
        end

        // R4: stopped generator stays quiet, restart is fresh
        write_stopped(0, 16'd1);
        n = 0;
        for (int k = 0; k < 50; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (os_tick) n++;
        end
        check("R4 no tick while stopped", n, 0);
        write_stopped(1, 16'd5000);
        run_count(300, n);
        stop_gen();
        run_count(300, n);
        check("R4 phase restarts from zero", n, exp_acc(300, 5000));

        // R6: mid-run write in integer mode waits for the wrap
        write_stopped(0, 16'd10);
        run_trace(20, 4, 16'd4, m);
        m_exp = '0;
        m_exp[1] = 1'b1; m_exp[11] = 1'b1; m_exp[15] = 1'b1; m_exp[19] = 1'b1;
        check("R6 integer deferred reload", m, m_exp);

        // R6: mid-run write in phase mode waits for the carry
        write_stopped(1, 16'h8000);
        run_trace(20, 3, 16'h4000, m);
        m_exp = '0;
        m_exp[2] = 1'b1; m_exp[4] = 1'b1; m_exp[8] = 1'b1;
        m_exp[12] = 1'b1; m_exp[16] = 1'b1; m_exp[20] = 1'b1;
        check("R6 phase deferred reload", m, m_exp);

        // R6: stopped write with a leftover pending value is the one used
        write_stopped(0, 16'd3);
        run_count(10, n);
        check("R6 stopped write applies", n, exp_div(10, 3));

        // R7: same reload in both modes
        write_stopped(1, 16'd3);
        run_count(50, n);
        check("R7 phase mode selected", n, exp_acc(50, 3));
        write_stopped(0, 16'd3);
        run_count(50, n);
        check("R7 integer mode selected", n, exp_div(50, 3));

        // R8: standard rates at an assumed 200 MHz input clock
        rate_check("R8 9600 integer",  0, 9600,   4);
        rate_check("R8 19200 phase",   1, 19200,  20);
        rate_check("R8 38400 phase",   1, 38400,  20);
        rate_check("R8 57600 phase",   1, 57600,  20);
        rate_check("R8 115200 phase",  1, 115200, 20);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule